// File: doc/BRIEF.md
# Block Gain and Clock-Skew Estimator

This block takes one channel of a time-interleaved converter after the chopping sign has been removed. From one block of that stream it estimates the channel's gain error and its clock-skew term. Two reference streams run alongside the sample stream, in step with it: a sine reference and a cosine reference, both generated elsewhere. The block assumes the stream fits the model y = G·V + G·T·W. It accumulates the three streams separately over the first and the second half of an L-sample block. Each half-sum is scaled to a mean by an arithmetic right shift. The two-unknown system that results is then solved in closed form.

The solver runs after the last sample of a block. It forms the cross products of the half means and obtains the skew term T from a first division. It then uses T to build the denominator of a second division, which yields the gain G. One shared sequential divider performs both divisions. If either divisor is zero, an error pulse is raised and the previously published estimates stay in place. Otherwise T and G are updated together and a valid pulse is raised. The design assumes that blocks arrive no faster than the solver finishes, which takes about 90 cycles with the default parameters.

Top module: `gain_skew_est`

## Requirements
- R1: After reset, `t_est` and `g_est` are zero, and `est_valid` and `zero_err` are low.
- R2: A block is L accepted samples. The first is the sample accepted with `blk_start` high. Accepted samples 0 to L/2-1 form half 1, and samples L/2 to L-1 form half 2.
- R3: A cycle with `in_valid` low is ignored, whatever `blk_start` and the data inputs carry. Valid samples that arrive while no block is open (before any `blk_start`, or after a block's L-th sample) are ignored.
- R4: Each half mean is the half-sum of a stream shifted arithmetically right by log2(L/2), which is the floor of the sum divided by L/2.
- R5: With half means y1, V1, W1, y2, V2, W2, the skew term is T = ((y2·V1 − y1·V2)·2^FRAC) / (y1·W2 − y2·W1). The division truncates toward zero. The result saturates to the signed OW-bit range and is published on `t_est` as a signed value with FRAC fraction bits.
- R6: The gain is G = (y1·2^FRAC) / (V1 + ((T·W1) >>> FRAC)), where T is the saturated skew term. The division truncates toward zero and the result saturates to OW bits. It is published on `g_est` in the same signed format with FRAC fraction bits.
- R7: `est_valid` is a one-cycle pulse raised only after both divisions have finished. `t_est` and `g_est` change only in the cycle in which `est_valid` is high.
- R8: If the skew divisor or the gain divisor is zero, `zero_err` pulses for one cycle instead of `est_valid`, and `t_est` and `g_est` keep their previous values.
- R9: An accepted sample with `blk_start` high while a block is open abandons the partial block and starts a new block at sample 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_start | input | 1 | Marks the accepted sample as sample 0 of a block |
| in_valid | input | 1 | The three data inputs carry a sample this cycle |
| y_in | input | DW | Demodulated channel sample, signed |
| v_in | input | DW | Sine reference sample, signed |
| w_in | input | DW | Cosine reference sample, signed |
| t_est | output | OW | Skew estimate, signed, FRAC fraction bits |
| g_est | output | OW | Gain estimate, signed, FRAC fraction bits |
| est_valid | output | 1 | One-cycle pulse: new estimates published |
| zero_err | output | 1 | One-cycle pulse: a divisor was zero, estimates held |

## Verification
Fully random blocks exercise the cross products, the signs of both quotients and the flooring of negative half-sums. Random blocks with bubbles, stray start flags and stray valid samples outside a block separate correct acceptance from samples leaking into a sum. A restarted partial block shows whether the counter re-arms. Directed blocks cover three cases, each of which a generic random pattern rarely reaches: an all-zero block (skew divisor zero), a block whose gain divisor alone is zero, and a block with a tiny skew divisor that forces saturation.

// File: rtl/gse_pkg.sv
// Shared declarations for the block gain/skew estimator.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package gse_pkg;

    // Sequencer states of the closed-form solver.
    typedef enum logic [3:0] {
        S_IDLE,
        S_PROD,
        S_DIFF,
        S_TDIV,
        S_TWAIT,
        S_GPROD,
        S_GDEN,
        S_GDIV,
        S_GWAIT
    } solve_st_t;

    // Stream indices inside the per-half sum arrays.
    localparam int IDX_Y = 0;
    localparam int IDX_V = 1;
    localparam int IDX_W = 2;

endpackage

// File: rtl/gse_half_accum.sv
// Accumulates the demodulated stream and both reference streams over the
// two halves of an L-sample block. Emits the six half-sums with a one-cycle
// strobe the cycle after the L-th accepted sample.
// Assumes L is a power of two, at least 4.
module gse_half_accum #(
    parameter int DW = 12,
    parameter int L  = 64,
    localparam int HALF = L / 2,
    localparam int HLOG = $clog2(HALF),
    localparam int CW   = $clog2(L),
    localparam int SW   = DW + HLOG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 blk_start,
    input  logic signed [DW-1:0] y_in,
    input  logic signed [DW-1:0] v_in,
    input  logic signed [DW-1:0] w_in,
    output logic signed [SW-1:0] sum_h1 [3],
    output logic signed [SW-1:0] sum_h2 [3],
    output logic                 sums_vld
);

    logic          active;
    logic [CW-1:0] cnt;
    logic          take;
    logic          in_first;
    logic          last;
    logic signed [DW-1:0] smp [3];
    logic signed [SW-1:0] acc1 [3];
    logic signed [SW-1:0] acc2 [3];

    assign smp[0] = y_in;
    assign smp[1] = v_in;
    assign smp[2] = w_in;

    // Acceptance and half selection for the current cycle.
    always_comb begin
        take     = in_valid && (blk_start || active);
        in_first = blk_start || (cnt < CW'(HALF));
        last     = take && !blk_start && (cnt == CW'(L - 1));
    end

    // Sample counter and open-block flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cnt      <= '0;
            sums_vld <= 1'b0;
        end else begin
            sums_vld <= last;
            if (take) begin
                if (blk_start) begin
                    active <= 1'b1;
                    cnt    <= CW'(1);
                end else begin
                    cnt <= cnt + CW'(1);
                    if (last) active <= 1'b0;
                end
            end
        end
    end

    // One accumulator pair per stream.
    for (genvar g = 0; g < 3; g++) begin : g_stream
        // Half-sum accumulation and hand-off at block end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc1[g]   <= '0;
                acc2[g]   <= '0;
                sum_h1[g] <= '0;
                sum_h2[g] <= '0;
            end else if (take) begin
                if (blk_start) begin
                    acc1[g] <= SW'(smp[g]);
                    acc2[g] <= '0;
                end else if (in_first) begin
                    acc1[g] <= acc1[g] + SW'(smp[g]);
                end else begin
                    acc2[g] <= acc2[g] + SW'(smp[g]);
                end
                if (last) begin
                    sum_h1[g] <= acc1[g];
                    sum_h2[g] <= acc2[g] + SW'(smp[g]);
                end
            end
        end
    end

    AST_IDLE_AFTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sums_vld |-> !active); // R2

    AST_OPEN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(in_valid && blk_start)); // R9

endmodule

// File: rtl/gse_seq_div.sv
// Signed restoring divider, one quotient bit per cycle, NW cycles per
// division. The quotient truncates toward zero. A zero divisor finishes on
// the next cycle with dz set. A start while busy is ignored.
module gse_seq_div #(
    parameter int NW  = 37,
    parameter int DVW = 25,
    localparam int CNW = $clog2(NW)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic signed [NW-1:0]  dividend,
    input  logic signed [DVW-1:0] divisor,
    output logic                  done,
    output logic                  dz,
    output logic signed [NW:0]    quot
);

    logic            busy;
    logic [CNW-1:0]  cnt;
    logic [DVW:0]    rem;
    logic [NW-1:0]   dq;
    logic [DVW-1:0]  dvs;
    logic [NW-1:0]   a_lat;
    logic            neg;
    logic [NW-1:0]   a_mag;
    logic [DVW-1:0]  d_mag;
    logic [DVW:0]    trial;
    logic            ge;
    logic [DVW:0]    rem_n;
    logic [NW-1:0]   q_fin;

    // Operand magnitudes and one restoring step.
    always_comb begin
        a_mag = dividend[NW-1] ? (~dividend + 1'b1) : dividend;
        d_mag = divisor[DVW-1] ? (~divisor + 1'b1) : divisor;
        trial = {rem[DVW-1:0], dq[NW-1]};
        ge    = trial >= {1'b0, dvs};
        rem_n = ge ? (trial - {1'b0, dvs}) : trial;
        q_fin = {dq[NW-2:0], ge};
    end

    // Division sequencing and signed result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            rem   <= '0;
            dq    <= '0;
            dvs   <= '0;
            a_lat <= '0;
            neg   <= 1'b0;
            done  <= 1'b0;
            dz    <= 1'b0;
            quot  <= '0;
        end else begin
            done <= 1'b0;
            dz   <= 1'b0;
            if (start && !busy) begin
                if (d_mag == '0) begin
                    done <= 1'b1;
                    dz   <= 1'b1;
                end else begin
                    busy  <= 1'b1;
                    cnt   <= '0;
                    rem   <= '0;
                    dq    <= a_mag;
                    a_lat <= a_mag;
                    dvs   <= d_mag;
                    neg   <= dividend[NW-1] ^ divisor[DVW-1];
                end
            end else if (busy) begin
                rem <= rem_n;
                dq  <= q_fin;
                cnt <= cnt + CNW'(1);
                if (cnt == CNW'(NW - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    quot <= neg ? -$signed({1'b0, q_fin}) : $signed({1'b0, q_fin});
                end
            end
        end
    end

    logic [NW-1:0]     q_chk;
    logic [NW+DVW-1:0] back;
    assign q_chk = quot[NW] ? NW'(-quot) : quot[NW-1:0];
    assign back  = (NW+DVW)'(q_chk) * (NW+DVW)'(dvs);

    AST_DIV_NOT_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dz) |-> (back <= (NW+DVW)'(a_lat))); // R5

    AST_DIV_NOT_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dz) |-> ((NW+DVW)'(a_lat) - back < (NW+DVW)'(dvs))); // R5

endmodule

// File: rtl/gse_solver.sv
// Turns six half-sums into the skew and gain estimates. Means come from an
// arithmetic shift. Cross products feed the skew division; the saturated
// skew then builds the gain divisor. One shared divider serves both.
// Assumes a new set of sums does not arrive while a solve is running
// (such sums are dropped).
module gse_solver
    import gse_pkg::*;
#(
    parameter int DW   = 12,
    parameter int HLOG = 5,
    parameter int FRAC = 12,
    parameter int OW   = 24,
    localparam int SW  = DW + HLOG,
    localparam int PW  = 2 * DW,
    localparam int DVW = PW + 1,
    localparam int NW  = PW + 1 + FRAC,
    localparam int GPW = OW + DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [SW-1:0] sum_h1 [3],
    input  logic signed [SW-1:0] sum_h2 [3],
    input  logic                 sums_vld,
    output logic signed [OW-1:0] t_est,
    output logic signed [OW-1:0] g_est,
    output logic                 est_valid,
    output logic                 zero_err
);

    localparam logic signed [NW:0] QMAX = {{(NW-OW+2){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [NW:0] QMIN = {{(NW-OW+2){1'b1}}, {(OW-1){1'b0}}};

    // Saturate a divider quotient to the published width.
    function automatic logic signed [OW-1:0] sat(input logic signed [NW:0] q);
        if (q > QMAX)      return OW'(QMAX);
        else if (q < QMIN) return OW'(QMIN);
        else               return OW'(q);
    endfunction

    solve_st_t st;
    logic signed [DW-1:0]  my1, mv1, mw1, my2, mv2, mw2;
    logic signed [PW-1:0]  p_a, p_b, p_c, p_d;
    logic signed [PW:0]    num, den;
    logic signed [OW-1:0]  t_new;
    logic signed [GPW-1:0] gprod;
    logic signed [DVW-1:0] gden;
    logic                  div_start;
    logic signed [NW-1:0]  div_a;
    logic signed [DVW-1:0] div_b;
    logic                  div_done;
    logic                  div_dz;
    logic signed [NW:0]    div_q;

    // Operand selection for the shared divider.
    always_comb begin
        div_start = (st == S_TDIV) || (st == S_GDIV);
        if (st == S_TDIV || st == S_TWAIT) begin
            div_a = NW'(num) <<< FRAC;
            div_b = DVW'(den);
        end else begin
            div_a = NW'(my1) <<< FRAC;
            div_b = gden;
        end
    end

    gse_seq_div #(.NW(NW), .DVW(DVW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .dz       (div_dz),
        .quot     (div_q)
    );

    // Solve sequencer with its datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            my1 <= '0; mv1 <= '0; mw1 <= '0;
            my2 <= '0; mv2 <= '0; mw2 <= '0;
            p_a <= '0; p_b <= '0; p_c <= '0; p_d <= '0;
            num <= '0; den <= '0;
            t_new     <= '0;
            gprod     <= '0;
            gden      <= '0;
            t_est     <= '0;
            g_est     <= '0;
            est_valid <= 1'b0;
            zero_err  <= 1'b0;
        end else begin
            est_valid <= 1'b0;
            zero_err  <= 1'b0;
            unique case (st)
                S_IDLE: if (sums_vld) begin
                    my1 <= DW'(sum_h1[IDX_Y] >>> HLOG);
                    mv1 <= DW'(sum_h1[IDX_V] >>> HLOG);
                    mw1 <= DW'(sum_h1[IDX_W] >>> HLOG);
                    my2 <= DW'(sum_h2[IDX_Y] >>> HLOG);
                    mv2 <= DW'(sum_h2[IDX_V] >>> HLOG);
                    mw2 <= DW'(sum_h2[IDX_W] >>> HLOG);
                    st  <= S_PROD;
                end
                S_PROD: begin
                    p_a <= PW'(my2) * PW'(mv1);
                    p_b <= PW'(my1) * PW'(mv2);
                    p_c <= PW'(my1) * PW'(mw2);
                    p_d <= PW'(my2) * PW'(mw1);
                    st  <= S_DIFF;
                end
                S_DIFF: begin
                    num <= (PW+1)'(p_a) - (PW+1)'(p_b);
                    den <= (PW+1)'(p_c) - (PW+1)'(p_d);
                    st  <= S_TDIV;
                end
                S_TDIV: st <= S_TWAIT;
                S_TWAIT: if (div_done) begin
                    if (div_dz) begin
                        zero_err <= 1'b1;
                        st       <= S_IDLE;
                    end else begin
                        t_new <= sat(div_q);
                        st    <= S_GPROD;
                    end
                end
                S_GPROD: begin
                    gprod <= GPW'(t_new) * GPW'(mw1);
                    st    <= S_GDEN;
                end
                S_GDEN: begin
                    gden <= DVW'(mv1) + DVW'(gprod >>> FRAC);
                    st   <= S_GDIV;
                end
                S_GDIV: st <= S_GWAIT;
                S_GWAIT: if (div_done) begin
                    if (div_dz) begin
                        zero_err <= 1'b1;
                    end else begin
                        t_est     <= t_new;
                        g_est     <= sat(div_q);
                        est_valid <= 1'b1;
                    end
                    st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(est_valid && zero_err)); // R8

    AST_T_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (t_est != $past(t_est)) |-> est_valid); // R7

    AST_G_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (g_est != $past(g_est)) |-> est_valid); // R7

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |=> !est_valid); // R7

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        zero_err |=> !zero_err); // R8

endmodule

// File: rtl/gain_skew_est.sv
// Top of the block gain/skew estimator: half-block accumulation followed by
// the closed-form two-unknown solver.
// Assumes L is a power of two (32, 64 or 128 in use) and FRAC <= OW.
module gain_skew_est #(
    parameter int DW   = 12,
    parameter int L    = 64,
    parameter int FRAC = 12,
    parameter int OW   = 24,
    localparam int HLOG = $clog2(L / 2),
    localparam int SW   = DW + HLOG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 blk_start,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] y_in,
    input  logic signed [DW-1:0] v_in,
    input  logic signed [DW-1:0] w_in,
    output logic signed [OW-1:0] t_est,
    output logic signed [OW-1:0] g_est,
    output logic                 est_valid,
    output logic                 zero_err
);

    logic signed [SW-1:0] sum_h1 [3];
    logic signed [SW-1:0] sum_h2 [3];
    logic                 sums_vld;

    gse_half_accum #(.DW(DW), .L(L)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .blk_start (blk_start),
        .y_in      (y_in),
        .v_in      (v_in),
        .w_in      (w_in),
        .sum_h1    (sum_h1),
        .sum_h2    (sum_h2),
        .sums_vld  (sums_vld)
    );

    gse_solver #(.DW(DW), .HLOG(HLOG), .FRAC(FRAC), .OW(OW)) u_solve (
        .clk       (clk),
        .rst_n     (rst_n),
        .sum_h1    (sum_h1),
        .sum_h2    (sum_h2),
        .sums_vld  (sums_vld),
        .t_est     (t_est),
        .g_est     (g_est),
        .est_valid (est_valid),
        .zero_err  (zero_err)
    );

endmodule

// File: tb/gain_skew_est_tb.sv
module gain_skew_est_tb;

    localparam int DW = 12, L = 64, HALF = L / 2, HLOG = 5, FRAC = 12, OW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blk_start = 1'b0, in_valid = 1'b0;
    logic signed [DW-1:0] y_in = '0, v_in = '0, w_in = '0;
    logic signed [OW-1:0] t_est, g_est;
    logic est_valid, zero_err;

    always #2.5 clk = ~clk;

    gain_skew_est #(.DW(DW), .L(L), .FRAC(FRAC), .OW(OW)) u_dut (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .in_valid(in_valid),
        .y_in(y_in), .v_in(v_in), .w_in(w_in),
        .t_est(t_est), .g_est(g_est), .est_valid(est_valid), .zero_err(zero_err)
    );

    int total = 0, bad = 0;
    bit finished = 0;
    int ya [L], va [L], wa [L];
    longint prev_t = 0, prev_g = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint satq(input longint q);
        longint mx = (64'sd1 <<< (OW - 1)) - 1;
        longint mn = -(64'sd1 <<< (OW - 1));
        if (q > mx) return mx;
        if (q < mn) return mn;
        return q;
    endfunction

    // Expected results from the requirement formulas.
    function automatic void model(output longint t, output longint g, output bit err);
        longint s[6];
        longint m[6];
        longint num, den, gd;
        for (int k = 0; k < 6; k++) s[k] = 0;
        for (int i = 0; i < L; i++) begin
            int o = (i < HALF) ? 0 : 3;
            s[o] += ya[i]; s[o+1] += va[i]; s[o+2] += wa[i];
        end
        for (int k = 0; k < 6; k++) m[k] = s[k] >>> HLOG;
        num = m[3] * m[1] - m[0] * m[4];
        den = m[0] * m[5] - m[3] * m[2];
        err = 0; t = 0; g = 0;
        if (den == 0) begin err = 1; return; end
        t  = satq((num <<< FRAC) / den);
        gd = m[1] + ((t * m[2]) >>> FRAC);
        if (gd == 0) begin err = 1; return; end
        g = satq((m[0] <<< FRAC) / gd);
    endfunction

    function automatic int rs();
        return int'($urandom_range(4094)) - 2047;
    endfunction

    // Drive one full block with optional bubbles carrying garbage (R3).
    task automatic send_block(input int gap_pct);
        for (int i = 0; i < L; i++) begin
            while (int'($urandom_range(99)) < gap_pct) begin
                @(negedge clk);
                in_valid = 0; blk_start = $urandom_range(1);
                y_in = DW'(rs()); v_in = DW'(rs()); w_in = DW'(rs());
            end
            @(negedge clk);
            in_valid = 1; blk_start = (i == 0);
            y_in = DW'(ya[i]); v_in = DW'(va[i]); w_in = DW'(wa[i]);
        end
        @(negedge clk);
        in_valid = 0; blk_start = 0;
    endtask

    task automatic check_result(input string tag);
        longint et, eg;
        bit eerr, got;
        model(et, eg, eerr);
        got = 0;
        for (int c = 0; c < 600 && !got; c++) begin
            @(negedge clk);
            if (est_valid || zero_err) got = 1;
        end
        chk(got, {tag, " R7 result pulse seen"}, got, 1);
        if (eerr) begin
            chk(zero_err && !est_valid, {tag, " R8 zero_err raised"}, zero_err, 1);
            chk(t_est == prev_t, {tag, " R8 t held"}, t_est, prev_t);
            chk(g_est == prev_g, {tag, " R8 g held"}, g_est, prev_g);
        end else begin
            chk(est_valid && !zero_err, {tag, " R7 est_valid"}, est_valid, 1);
            chk(t_est == et, {tag, " R5 skew"}, t_est, et);
            chk(g_est == eg, {tag, " R6 gain"}, g_est, eg);
            prev_t = et; prev_g = eg;
        end
        @(negedge clk);
        chk(!est_valid && !zero_err, {tag, " R7 single-cycle pulse"}, est_valid | zero_err, 0);
    endtask

    task automatic fill_random();
        for (int i = 0; i < L; i++) begin ya[i] = rs(); va[i] = rs(); wa[i] = rs(); end
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(t_est == 0, "R1 t reset", t_est, 0);
        chk(g_est == 0, "R1 g reset", g_est, 0);
        chk(!est_valid, "R1 valid reset", est_valid, 0);
        chk(!zero_err, "R1 err reset", zero_err, 0);
        rst_n = 1;
        @(negedge clk);

        // R3: valid samples with no block open are ignored
        repeat (10) begin
            @(negedge clk);
            in_valid = 1; blk_start = 0;
            y_in = DW'(rs()); v_in = DW'(rs()); w_in = DW'(rs());
        end
        @(negedge clk); in_valid = 0;
        repeat (5) @(negedge clk);
        chk(!est_valid && !zero_err && t_est == 0, "R3 no block opened", t_est, 0);

        // R2 R4 R5 R6: random blocks
        fill_random(); send_block(0); check_result("rand0 R2 R4");

        // R3: bubbles with garbage and stray start flags
        fill_random(); send_block(30); check_result("gaps R3");

        // R9: partial block abandoned by a new start
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            in_valid = 1; blk_start = (i == 0);
            y_in = DW'(rs()); v_in = DW'(rs()); w_in = DW'(rs());
        end
        fill_random(); send_block(0); check_result("restart R9");

        // R8: all-zero block, skew divisor zero
        for (int i = 0; i < L; i++) begin ya[i] = 0; va[i] = 0; wa[i] = 0; end
        send_block(0); check_result("zero-den R8");

        // R8: gain divisor zero only
        for (int i = 0; i < L; i++) begin
            ya[i] = (i < HALF) ? 100 : 0;
            va[i] = (i < HALF) ? 0 : 5;
            wa[i] = (i < HALF) ? 0 : 50;
        end
        send_block(0); check_result("gain-den R8");

        // R5: saturation of the skew term
        for (int i = 0; i < L; i++) begin
            ya[i] = (i < HALF) ? 1 : 2000;
            va[i] = (i < HALF) ? 2000 : 0;
            wa[i] = (i < HALF) ? 0 : 1;
        end
        send_block(0); check_result("sat R5");

        // R4: negative sums that are not multiples of L/2
        for (int i = 0; i < L; i++) begin
            ya[i] = (i % 3 == 0) ? -7 : 3 - i;
            va[i] = (i % 5 == 0) ? -1500 : 900 - 13 * i;
            wa[i] = (i % 2 == 0) ? -333 : 41 + i;
        end
        send_block(0); check_result("floor R4");

        for (int b = 0; b < 6; b++) begin
            fill_random(); send_block(b * 5); check_result("rand R5 R6");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule